// File: doc/BRIEF.md
# Dual-Port DDR Burst SRAM Front End

This block is a synthesizable model of a separate-I/O synchronous SRAM with a read port and a write port. Both ports share one address bus, and every access moves a fixed two-word burst at double data rate. The two clock phases of the memory are modelled as alternate rising edges of one double-rate clock `clk`. A phase state machine (states `PH_K` and `PH_KB`, with transition `PH_K -> PH_KB` on every K edge and `PH_KB -> PH_K` on every K-bar edge) marks which edge is next. The first edge after reset is a K edge.

A read is requested by holding `rd_sel_n` low on a K edge. The address is taken from the shared bus on that edge. The two words of the pair come out on `rdata` on consecutive edges after a delay of one or one-and-a-half K cycles, chosen by `lat_mode`, and each word is marked by `rvalid`. A write is requested by holding `wr_sel_n` low on a K-bar edge. Its two data words and their per-lane enables follow on the next K edge and the next K-bar edge. A write state machine tracks this with the states `W_IDLE`, `W_LOW` and `W_HIGH`:
- `W_IDLE -> W_LOW` when a write is taken.
- `W_LOW -> W_HIGH` on the K edge, which captures word 0.
- `W_HIGH -> W_LOW` on the K-bar edge if a new write is taken there; otherwise `W_HIGH -> W_IDLE`. This edge captures word 1 and commits both words.

Reads always see the most recent write, including a write that is still being collected. `rd_echo` is a free-running capture strobe that is high after K edges.

Top module: `ddr_burst_sram`

## Requirements
- R1: While `rst` is high on a clock edge, `rvalid`, `rdata` and `rd_echo` become 0. The array contents are not cleared.
- R2: After reset, `rd_echo` is 1 after the first edge and then toggles on every edge. It is 1 exactly after K edges, where edges are counted from 1 and the odd ones are K edges.
- R3: A read is taken only on a K edge with `rd_sel_n` low. `rd_sel_n` low on a K-bar edge starts nothing.
- R4: With `lat_mode` = 0, word 0 of a read taken on edge n is on `rdata` with `rvalid` = 1 after edge n+2, and word 1 after edge n+3.
- R5: With `lat_mode` = 1, word 0 appears after edge n+3 and word 1 after edge n+4. `lat_mode` is held steady while reads are outstanding.
- R6: A write taken on K-bar edge m with address A stores `wdata` from edge m+1 as word 0 of A and `wdata` from edge m+2 as word 1 of A.
- R7: Each word has its own `wbe_n` (active low). If bit i is 0, data bits [9i+8:9i] of that word are written. If bit i is 1, that lane of the stored word is left unchanged.
- R8: On an edge that delivers no read word, `rvalid` becomes 0 and `rdata` keeps its value.
- R9: A read returns the latest data for its address, in both latency modes. This includes a write taken on the K-bar edge of the same K cycle, merged lane by lane, and a write in the K cycle just before.
- R10: Reads taken on every K edge give an unbroken stream of words. Writes may also be taken on every K-bar edge.
- R11: `wr_sel_n` low on a K edge starts no write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Double-rate clock; odd edges after reset are K, even edges are K-bar |
| rst | input | 1 | Synchronous active-high reset |
| lat_mode | input | 1 | 0: one-cycle read latency; 1: one-and-a-half-cycle read latency |
| rd_sel_n | input | 1 | Active-low read request, sampled on K edges |
| wr_sel_n | input | 1 | Active-low write request, sampled on K-bar edges |
| addr | input | AW (8) | Shared address bus, read address on K edges and write address on K-bar edges |
| wdata | input | W (18) | Write data word |
| wbe_n | input | LANES (2) | Active-low lane write enables for the current write word |
| rdata | output | W (18) | Read data word |
| rvalid | output | 1 | High while `rdata` carries a newly delivered word |
| rd_echo | output | 1 | Capture strobe, high after K edges |

## Verification
The embedded properties check the following on every cycle:
- both read latencies, from the request at the ports to `rvalid`;
- the alternation of `rd_echo`;
- that `rdata` holds while `rvalid` is low;
- that the write state machine collects word 0 only on K edges and starts a write only after a K-bar edge;
- that at most one word is selected for output on any edge.

The data content can only be shown by the bench's scenarios. This covers lane-masked writes, same-cycle and next-cycle coherency in both modes, back-to-back bursts, and requests placed on the wrong phase being ignored. For these, the scoreboard compares every delivered word against a reference memory that is updated in request order.

// File: rtl/dbs_pkg.sv
package dbs_pkg;
    typedef enum logic {
        PH_K  = 1'b0,
        PH_KB = 1'b1
    } phase_e;

    typedef enum logic [1:0] {
        W_IDLE = 2'd0,
        W_LOW  = 2'd1,
        W_HIGH = 2'd2
    } wstate_e;
endpackage

// File: rtl/dbs_phase_fsm.sv
module dbs_phase_fsm
    import dbs_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    output phase_e ph,
    output logic   echo
);
    phase_e ph_nx;

    always_comb begin
        unique case (ph)
            PH_K:  ph_nx = PH_KB;
            PH_KB: ph_nx = PH_K;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) ph <= PH_K;
        else     ph <= ph_nx;
    end

    always_ff @(posedge clk) begin
        if (rst) echo <= 1'b0;
        else     echo <= (ph == PH_K);
    end

    // R2: strobe alternates on every edge once out of reset
    p_echo_alt_r2: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (echo != $past(echo)));
endmodule

// File: rtl/dbs_wr_ctrl.sv
module dbs_wr_ctrl
    import dbs_pkg::*;
#(
    parameter int AW    = 8,
    parameter int W     = 18,
    parameter int LANES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  phase_e           ph,
    input  logic             wr_sel_n,
    input  logic [AW-1:0]    addr,
    input  logic [W-1:0]     wdata,
    input  logic [LANES-1:0] wbe_n,
    output wstate_e          st,
    output logic [AW-1:0]    waddr,
    output logic [W-1:0]     w0_q,
    output logic [LANES-1:0] be0_q,
    output logic             commit
);
    wstate_e st_nx;
    logic    take;

    assign take = (ph == PH_KB) && !wr_sel_n && (st != W_LOW);

    always_comb begin
        st_nx = st;
        unique case (st)
            W_IDLE: if (take)        st_nx = W_LOW;
            W_LOW:  if (ph == PH_K)  st_nx = W_HIGH;
            W_HIGH: if (ph == PH_KB) st_nx = take ? W_LOW : W_IDLE;
            default:                 st_nx = W_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) st <= W_IDLE;
        else     st <= st_nx;
    end

    always_ff @(posedge clk) begin
        if (take) waddr <= addr;
        if (st == W_LOW && ph == PH_K) begin
            w0_q  <= wdata;
            be0_q <= ~wbe_n;
        end
    end

    assign commit = (st == W_HIGH) && (ph == PH_KB);

    // R6: word 0 is collected only on K edges
    p_low_on_k_r6: assert property (@(posedge clk) disable iff (rst)
        (st == W_LOW) |-> (ph == PH_K));
    // R11: a write starts only after a K-bar edge
    p_take_kb_r11: assert property (@(posedge clk) disable iff (rst)
        $rose(st == W_LOW) |-> ($past(ph) == PH_KB));
endmodule

// File: rtl/dbs_rd_pipe.sv
module dbs_rd_pipe
    import dbs_pkg::*;
#(
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  phase_e        ph,
    input  logic          rd_sel_n,
    input  logic [AW-1:0] addr,
    input  logic          lat_mode,
    output logic          fire0,
    output logic          fire1,
    output logic [AW-1:0] faddr
);
    localparam int NSTG = 4;

    logic [NSTG-1:0] v;
    logic [NSTG-1:0] s;
    logic [AW-1:0]   a [NSTG];
    logic f0_fast, f0_slow, f1_fast, f1_slow;

    always_ff @(posedge clk) begin
        if (rst) v[0] <= 1'b0;
        else     v[0] <= (ph == PH_K) && !rd_sel_n;
        s[0] <= lat_mode;
        a[0] <= addr;
    end

    for (genvar k = 1; k < NSTG; k++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) v[k] <= 1'b0;
            else     v[k] <= v[k-1];
            s[k] <= s[k-1];
            a[k] <= a[k-1];
        end
    end

    assign f0_fast = v[1] && !s[1];
    assign f0_slow = v[2] &&  s[2];
    assign f1_fast = v[2] && !s[2];
    assign f1_slow = v[3] &&  s[3];

    assign fire0 = f0_fast || f0_slow;
    assign fire1 = !fire0 && (f1_fast || f1_slow);

    always_comb begin
        if (f0_fast)      faddr = a[1];
        else if (fire0)   faddr = a[2];
        else if (f1_fast) faddr = a[2];
        else              faddr = a[3];
    end

    // R10: with a steady mode, at most one word is due per edge
    p_single_word_r10: assert property (@(posedge clk) disable iff (rst)
        $onehot0({f0_fast, f0_slow, f1_fast, f1_slow}));
endmodule

// File: rtl/dbs_bank.sv
module dbs_bank #(
    parameter int DEPTH = 256,
    parameter int LANES = 2,
    parameter int BYTE  = 9,
    localparam int AW   = $clog2(DEPTH),
    localparam int W    = LANES * BYTE
) (
    input  logic             clk,
    input  logic             we,
    input  logic [AW-1:0]    waddr,
    input  logic [W-1:0]     d0,
    input  logic [LANES-1:0] be0,
    input  logic [W-1:0]     d1,
    input  logic [LANES-1:0] be1,
    input  logic [AW-1:0]    raddr,
    output logic [W-1:0]     q0,
    output logic [W-1:0]     q1
);
    logic [W-1:0] lo_mem [DEPTH];
    logic [W-1:0] hi_mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            for (int i = 0; i < LANES; i++) begin
                if (be0[i]) lo_mem[waddr][i*BYTE +: BYTE] <= d0[i*BYTE +: BYTE];
                if (be1[i]) hi_mem[waddr][i*BYTE +: BYTE] <= d1[i*BYTE +: BYTE];
            end
        end
    end

    assign q0 = lo_mem[raddr];
    assign q1 = hi_mem[raddr];
endmodule

// File: rtl/ddr_burst_sram.sv
module ddr_burst_sram
    import dbs_pkg::*;
#(
    parameter int DEPTH = 256,
    parameter int LANES = 2,
    parameter int BYTE  = 9,
    localparam int AW   = $clog2(DEPTH),
    localparam int W    = LANES * BYTE
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             lat_mode,
    input  logic             rd_sel_n,
    input  logic             wr_sel_n,
    input  logic [AW-1:0]    addr,
    input  logic [W-1:0]     wdata,
    input  logic [LANES-1:0] wbe_n,
    output logic [W-1:0]     rdata,
    output logic             rvalid,
    output logic             rd_echo
);
    phase_e           ph;
    wstate_e          wst;
    logic [AW-1:0]    waddr, faddr;
    logic [W-1:0]     w0_q, q0, q1, base, word;
    logic [LANES-1:0] be0_q;
    logic             commit, fire0, fire1;

    function automatic logic [W-1:0] lane_mix(logic [W-1:0] old_w,
                                              logic [W-1:0] new_w,
                                              logic [LANES-1:0] en);
        logic [W-1:0] r;
        r = old_w;
        for (int i = 0; i < LANES; i++)
            if (en[i]) r[i*BYTE +: BYTE] = new_w[i*BYTE +: BYTE];
        return r;
    endfunction

    dbs_phase_fsm u_phase (
        .clk (clk), .rst (rst), .ph (ph), .echo (rd_echo)
    );

    dbs_wr_ctrl #(.AW(AW), .W(W), .LANES(LANES)) u_wr (
        .clk (clk), .rst (rst), .ph (ph), .wr_sel_n (wr_sel_n),
        .addr (addr), .wdata (wdata), .wbe_n (wbe_n), .st (wst),
        .waddr (waddr), .w0_q (w0_q), .be0_q (be0_q), .commit (commit)
    );

    dbs_rd_pipe #(.AW(AW)) u_rd (
        .clk (clk), .rst (rst), .ph (ph), .rd_sel_n (rd_sel_n),
        .addr (addr), .lat_mode (lat_mode),
        .fire0 (fire0), .fire1 (fire1), .faddr (faddr)
    );

    dbs_bank #(.DEPTH(DEPTH), .LANES(LANES), .BYTE(BYTE)) u_bank (
        .clk (clk), .we (commit), .waddr (waddr),
        .d0 (w0_q), .be0 (be0_q), .d1 (wdata), .be1 (~wbe_n),
        .raddr (faddr), .q0 (q0), .q1 (q1)
    );

    // coherency: words of a same-cycle write still in flight override the array
    always_comb begin
        base = fire0 ? q0 : q1;
        word = base;
        if (ph == PH_K && fire0 && wst == W_LOW && waddr == faddr)
            word = lane_mix(base, wdata, ~wbe_n);
        else if (ph == PH_KB && wst == W_HIGH && waddr == faddr)
            word = fire0 ? lane_mix(base, w0_q, be0_q)
                         : lane_mix(base, wdata, ~wbe_n);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rvalid <= 1'b0;
            rdata  <= '0;
        end else begin
            rvalid <= fire0 || fire1;
            if (fire0 || fire1) rdata <= word;
        end
    end

    // R4: one-cycle mode delivers two words, starting two edges on
    p_fast_lat_r4: assert property (@(posedge clk) disable iff (rst)
        (ph == PH_K && !rd_sel_n && !lat_mode) |=> ##2 rvalid ##1 rvalid);
    // R5: one-and-a-half-cycle mode starts three edges on
    p_slow_lat_r5: assert property (@(posedge clk) disable iff (rst)
        (ph == PH_K && !rd_sel_n && lat_mode) |=> ##3 rvalid ##1 rvalid);
    // R8: output word is held when nothing is delivered
    p_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (!rvalid && !$past(rst)) |-> $stable(rdata));
endmodule

// File: tb/sim_ddr_burst_sram.sv
module sim_ddr_burst_sram;
    localparam int DEPTH = 256;
    localparam int LN    = 2;
    localparam int AW    = 8;
    localparam int W     = 18;

    logic clk = 1'b0, rst = 1'b1, lat_mode = 1'b0;
    logic rd_sel_n = 1'b1, wr_sel_n = 1'b1;
    logic [AW-1:0] addr = '0;
    logic [W-1:0]  wdata = '0;
    logic [LN-1:0] wbe_n = '1;
    logic [W-1:0]  rdata;
    logic rvalid, rd_echo;

    always #4 clk = ~clk;

    ddr_burst_sram u0 (
        .clk (clk), .rst (rst), .lat_mode (lat_mode), .rd_sel_n (rd_sel_n),
        .wr_sel_n (wr_sel_n), .addr (addr), .wdata (wdata), .wbe_n (wbe_n),
        .rdata (rdata), .rvalid (rvalid), .rd_echo (rd_echo)
    );

    int checks = 0, errors = 0, ecnt = 0;
    always @(posedge clk) begin
        if (rst) ecnt <= 0;
        else     ecnt <= ecnt + 1;
    end

    typedef struct {
        int           due;
        logic [W-1:0] val;
        string        tag;
    } exp_t;
    exp_t sb[$];

    logic [W-1:0]  mlo [DEPTH];
    logic [W-1:0]  mhi [DEPTH];
    logic [W-1:0]  pd0 = '0, pd1 = '0, last = '0;
    logic [LN-1:0] pbe0 = '1, pbe1 = '1;
    string cur_tag = "R4";

    task automatic chk(bit ok, string t, logic [W-1:0] act, logic [W-1:0] ex);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s act=%h exp=%h t=%0t", t, act, ex, $time);
        end
    endtask

    // monitor: pops scoreboard entries when they fall due
    always @(negedge clk) begin
        if (!rst && ecnt > 0) begin
            chk(rd_echo == ecnt[0], "R2 echo", {17'b0, rd_echo}, {17'b0, ecnt[0]});
            if (sb.size() > 0 && sb[0].due == ecnt) begin
                chk(rvalid && rdata == sb[0].val, sb[0].tag, rdata, sb[0].val);
                void'(sb.pop_front());
            end else begin
                chk(!rvalid && rdata == last, "R8 idle hold (also R3)", rdata, last);
            end
            last = rdata;
        end
    end

    task automatic mwrite(logic [AW-1:0] a, logic [W-1:0] d0, logic [W-1:0] d1,
                          logic [LN-1:0] b0, logic [LN-1:0] b1);
        for (int i = 0; i < LN; i++) begin
            if (!b0[i]) mlo[a][i*9 +: 9] = d0[i*9 +: 9];
            if (!b1[i]) mhi[a][i*9 +: 9] = d1[i*9 +: 9];
        end
    endtask

    // driver: one K cycle (K half then K-bar half), called at a negedge before a K edge
    task automatic kcycle(bit rd, logic [AW-1:0] ra, bit wr, logic [AW-1:0] wa,
                          logic [W-1:0] d0, logic [W-1:0] d1,
                          logic [LN-1:0] b0, logic [LN-1:0] b1, bit glitch);
        int n, lat;
        exp_t e;
        if (wr) mwrite(wa, d0, d1, b0, b1);
        n   = ecnt + 1;
        lat = lat_mode ? 3 : 2;
        if (rd) begin
            e.tag = cur_tag;
            e.due = n + lat;     e.val = mlo[ra]; sb.push_back(e);
            e.due = n + lat + 1; e.val = mhi[ra]; sb.push_back(e);
        end
        rd_sel_n = !rd; wr_sel_n = !glitch; addr = ra; wdata = pd0; wbe_n = pbe0;
        @(negedge clk);
        rd_sel_n = !glitch; wr_sel_n = !wr; addr = wa; wdata = pd1; wbe_n = pbe1;
        @(negedge clk);
        pd0 = d0; pd1 = d1;
        pbe0 = wr ? b0 : '1;
        pbe1 = wr ? b1 : '1;
    endtask

    task automatic idle(int k);
        for (int i = 0; i < k; i++) kcycle(0, '0, 0, '0, '0, '0, '1, '1, 0);
    endtask

    initial begin
        #(8 * 100000);
        errors++;
        $display("FAIL watchdog expired (R10 stream stalled)");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        chk(rvalid == 1'b0, "R1 rvalid in reset", {17'b0, rvalid}, '0);
        chk(rdata == '0, "R1 rdata in reset", rdata, '0);
        chk(rd_echo == 1'b0, "R1 echo in reset", {17'b0, rd_echo}, '0);
        rst = 1'b0;

        // full writes to addresses 0..15, back to back
        for (int a = 0; a < 16; a++)
            kcycle(0, '0, 1, AW'(a), W'(18'h01000 + a * 37), W'(18'h2A000 ^ a * 91),
                   2'b00, 2'b00, 0);
        idle(2);
        // R4/R6/R10: continuous fast reads
        cur_tag = "R4 R6 R10 fast readback";
        for (int a = 0; a < 16; a++) kcycle(1, AW'(a), 0, '0, '0, '0, '1, '1, 0);
        idle(2);

        // R7: lane-masked writes, one lane per word
        kcycle(0, '0, 1, 8'd3, 18'h3FFFF, 18'h3FFFF, 2'b10, 2'b01, 0);
        kcycle(0, '0, 1, 8'd5, 18'h15555, 18'h0AAAA, 2'b01, 2'b11, 0);
        idle(1);
        cur_tag = "R7 lane mask";
        kcycle(1, 8'd3, 0, '0, '0, '0, '1, '1, 0);
        kcycle(1, 8'd5, 0, '0, '0, '0, '1, '1, 0);
        idle(3);

        // R5: slow mode reads
        lat_mode = 1'b1;
        cur_tag = "R5 slow readback";
        for (int a = 6; a < 10; a++) kcycle(1, AW'(a), 0, '0, '0, '0, '1, '1, 0);
        idle(2);
        // R9 slow: same-cycle write merged per lane, then next-cycle read
        cur_tag = "R9 slow same-cycle bypass";
        kcycle(1, 8'd4, 1, 8'd4, 18'h12345, 18'h2BCDE, 2'b01, 2'b10, 0);
        cur_tag = "R9 slow next-cycle";
        kcycle(1, 8'd4, 1, 8'd4, 18'h0F0F0, 18'h33333, 2'b10, 2'b00, 0);
        kcycle(1, 8'd4, 0, '0, '0, '0, '1, '1, 0);
        idle(3);

        // R9 fast
        lat_mode = 1'b0;
        cur_tag = "R9 fast same-cycle bypass";
        kcycle(1, 8'd7, 1, 8'd7, 18'h2468A, 18'h13579, 2'b10, 2'b01, 0);
        cur_tag = "R9 fast next-cycle";
        kcycle(1, 8'd7, 1, 8'd7, 18'h11111, 18'h22222, 2'b00, 2'b10, 0);
        kcycle(1, 8'd7, 0, '0, '0, '0, '1, '1, 0);
        idle(2);

        // R3/R11: selects on the wrong phase do nothing
        kcycle(0, 8'd9, 0, 8'd10, 18'h3FFFF, 18'h3FFFF, 2'b00, 2'b00, 1);
        idle(2);
        cur_tag = "R11 wrong-phase write ignored";
        kcycle(1, 8'd9, 0, '0, '0, '0, '1, '1, 0);
        idle(2);

        // mixed random traffic in both modes
        for (int m = 0; m < 2; m++) begin
            lat_mode = m[0];
            cur_tag = m == 0 ? "R10 random fast" : "R10 random slow";
            for (int i = 0; i < 150; i++) begin
                logic [AW-1:0] ra, wa;
                ra = AW'($urandom_range(0, 15));
                wa = AW'($urandom_range(0, 15));
                kcycle(1'($urandom_range(0, 1)), ra, 1'($urandom_range(0, 1)), wa,
                       W'($urandom), W'($urandom), LN'($urandom), LN'($urandom), 0);
            end
            idle(3);
        end

        chk(sb.size() == 0, "R10 scoreboard drained", W'(sb.size()), '0);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule